// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Per-Entry Page Masks

This block caches virtual-to-physical page translations in a small, fully associative table. Each slot holds a virtual page number, a per-slot mask, an address-space tag, a global flag, two valid flags and two physical frame numbers. Set bits in the mask mark page-number bits that the slot does not compare. This lets one slot cover a larger page.

A lookup port takes a page number and the current address-space tag. In the same cycle it returns hit, the slot index and the slot contents. A second, independent probe port returns only the index of the matching slot, or all ones when no slot matches. Software-style maintenance uses four other ports: an indexed write, an indexed read, a flush of the whole table, and a read at a rotating next-use pointer that can advance. Two saturating counters tally the hits and misses of lookup strobes.

Top module: `tlb_fa`

## Requirements
- R1: A slot matches a page number when the two agree on every bit where the slot's mask is 0. Bits where the mask is 1 are not compared.
- R2: A page-number match is a hit only if the slot's global flag is 1 or its stored address-space tag equals the lookup tag.
- R3: `pb_idx_o` is IDX_W+1 bits wide. It gives the matching slot index zero-extended, or all ones (-1) when no slot matches.
- R4: A slot is live when either valid flag is 1. A slot with both valid flags 0 never hits.
- R5: A slot is packed MSB first as {vpn, mask, asid, global, valid1, valid0, pfn1, pfn0}. With PFN_W=P this puts valid0 at bit 2P, valid1 at 2P+1 and global at 2P+2. A write with `wr_idx_i` < N_ENTRIES replaces the whole slot at the clock edge. The slot takes part in lookups from the next cycle and not in the cycle of the write.
- R6: A write with `wr_idx_i` >= N_ENTRIES changes no slot. `wr_err_o` is then 1 for exactly the one cycle after that write.
- R7: Flush clears every slot to zero, valid flags included, and sets the next-use pointer to 0 at the clock edge. Flush takes priority over a write and over an advance in the same cycle.
- R8: `rd_entry_o` shows the slot at `rd_idx_i` in the same cycle.
- R9: `nu_entry_o` shows the slot at the next-use pointer `nu_idx_o`. With `nu_adv_i` high the pointer increments at the clock edge and wraps from N_ENTRIES-1 to 0. With `nu_adv_i` low the pointer holds.
- R10: Lookup and probe are combinational. When several slots match, the lowest index wins. On a miss `lk_idx_o` and `lk_entry_o` are zero.
- R11: On each cycle with `lk_valid_i` high, either the hit counter or the miss counter increments, according to `lk_hit_o`. Both counters saturate at all ones. Reset clears them and flush does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_valid_i | input | 1 | Lookup strobe, counted by the statistics counters |
| lk_vpn_i | input | VPN_W | Lookup virtual page number |
| lk_asid_i | input | ASID_W | Lookup address-space tag |
| lk_hit_o | output | 1 | Lookup hit |
| lk_idx_o | output | IDX_W | Index of the winning slot |
| lk_entry_o | output | EW | Contents of the winning slot |
| pb_vpn_i | input | VPN_W | Probe virtual page number |
| pb_asid_i | input | ASID_W | Probe address-space tag |
| pb_idx_o | output | IDX_W+1 | Probe result, all ones on no match |
| wr_en_i | input | 1 | Indexed write strobe |
| wr_idx_i | input | IDX_W+1 | Write index, may be out of range |
| wr_entry_i | input | EW | Packed slot to write |
| wr_err_o | output | 1 | Out-of-range write seen last cycle |
| rd_idx_i | input | IDX_W | Indexed read address |
| rd_entry_o | output | EW | Slot at the read address |
| flush_i | input | 1 | Clear the whole table and the pointer |
| nu_adv_i | input | 1 | Advance the next-use pointer |
| nu_idx_o | output | IDX_W | Next-use pointer |
| nu_entry_o | output | EW | Slot at the next-use pointer |
| hit_cnt_o | output | CNT_W | Saturating hit count |
| miss_cnt_o | output | CNT_W | Saturating miss count |

## Verification
A corrupted slot, mask or valid flag shows up in the same cycle on the indexed and next-use read ports. It also shows up at the first lookup or probe that covers that slot, as a wrong hit, a wrong index or a wrong contents vector. A pointer that steps wrongly is visible on `nu_idx_o` one cycle after the bad advance. A counter that fails to saturate or to hold across a flush shows up at the next comparison of the counts. The bench mixes seeded random writes, lookups, reads and advances over a few overlapping page numbers and masks with directed cases for same-cycle write visibility, overlapping slots, dead slots, out-of-range writes, pointer wrap and flush.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // packed slot: {vpn, mask, asid, glb, v1, v0, pfn1, pfn0}
  function automatic int entry_width(int vpn_w, int asid_w, int pfn_w);
    return 2*vpn_w + asid_w + 3 + 2*pfn_w;
  endfunction
  function automatic int off_v0(int pfn_w);
    return 2*pfn_w;
  endfunction
  function automatic int off_v1(int pfn_w);
    return 2*pfn_w + 1;
  endfunction
  function automatic int off_glb(int pfn_w);
    return 2*pfn_w + 2;
  endfunction
  function automatic int off_asid(int pfn_w);
    return 2*pfn_w + 3;
  endfunction
  function automatic int off_mask(int asid_w, int pfn_w);
    return 2*pfn_w + 3 + asid_w;
  endfunction
  function automatic int off_vpn(int vpn_w, int asid_w, int pfn_w);
    return 2*pfn_w + 3 + asid_w + vpn_w;
  endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int N_ENTRIES = 8,
  parameter int IDX_W     = 3,
  parameter int EW        = 91
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        flush_i,
  input  logic                        wr_en_i,
  input  logic [IDX_W:0]              wr_idx_i,
  input  logic [EW-1:0]               wr_entry_i,
  output logic                        wr_err_o,
  input  logic [IDX_W-1:0]            rd_idx_i,
  output logic [EW-1:0]               rd_entry_o,
  output logic [N_ENTRIES-1:0][EW-1:0] tab_o
);
  localparam logic [IDX_W:0] NUM = (IDX_W+1)'(N_ENTRIES);

  logic [N_ENTRIES-1:0][EW-1:0] tab_q;
  logic                         err_q;
  logic                         wr_in_rng;
  logic                         rd_in_rng;

  assign wr_in_rng = wr_idx_i < NUM;
  assign rd_in_rng = {1'b0, rd_idx_i} < NUM;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tab_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= wr_en_i && !wr_in_rng;
      if (flush_i) begin
        tab_q <= '0;
      end else if (wr_en_i && wr_in_rng) begin
        tab_q[wr_idx_i[IDX_W-1:0]] <= wr_entry_i;
      end
    end
  end

  assign wr_err_o   = err_q;
  assign rd_entry_o = rd_in_rng ? tab_q[rd_idx_i] : '0;
  assign tab_o      = tab_q;

  AST_WR_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !flush_i && wr_in_rng) |=> tab_q[$past(wr_idx_i[IDX_W-1:0])] == $past(wr_entry_i)); // R5
  AST_WR_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !flush_i && !wr_in_rng) |=> ($stable(tab_q) && wr_err_o)); // R6
  AST_FLUSH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (tab_q == '0)); // R7
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N_ENTRIES = 8,
  parameter int VPN_W     = 20,
  parameter int ASID_W    = 8,
  parameter int PFN_W     = 20,
  parameter int IDX_W     = 3,
  parameter int EW        = 91
) (
  input  logic [N_ENTRIES-1:0][EW-1:0] tab_i,
  input  logic [VPN_W-1:0]             vpn_i,
  input  logic [ASID_W-1:0]            asid_i,
  output logic                         hit_o,
  output logic [IDX_W-1:0]             idx_o,
  output logic [EW-1:0]                entry_o
);
  localparam int O_V0   = tlb_pkg::off_v0(PFN_W);
  localparam int O_V1   = tlb_pkg::off_v1(PFN_W);
  localparam int O_GLB  = tlb_pkg::off_glb(PFN_W);
  localparam int O_ASID = tlb_pkg::off_asid(PFN_W);
  localparam int O_MASK = tlb_pkg::off_mask(ASID_W, PFN_W);
  localparam int O_VPN  = tlb_pkg::off_vpn(VPN_W, ASID_W, PFN_W);

  logic [N_ENTRIES-1:0] match;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    logic [VPN_W-1:0]  e_vpn;
    logic [VPN_W-1:0]  e_mask;
    logic [ASID_W-1:0] e_asid;
    logic              e_live;
    logic              e_glb;
    assign e_vpn    = tab_i[g][O_VPN +: VPN_W];
    assign e_mask   = tab_i[g][O_MASK +: VPN_W];
    assign e_asid   = tab_i[g][O_ASID +: ASID_W];
    assign e_live   = tab_i[g][O_V0] | tab_i[g][O_V1];
    assign e_glb    = tab_i[g][O_GLB];
    assign match[g] = e_live && (((vpn_i ^ e_vpn) & ~e_mask) == '0)
                      && (e_glb || (e_asid == asid_i));
  end

  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = N_ENTRIES-1; i >= 0; i--) begin
      if (match[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o   = |match;
  assign entry_o = hit_o ? tab_i[idx_o] : '0;
endmodule

// File: rtl/tlb_nlu.sv
module tlb_nlu #(
  parameter int N_ENTRIES = 8,
  parameter int IDX_W     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES-1);

  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ptr_q <= '0;
    else if (flush_i)     ptr_q <= '0;
    else if (adv_i)       ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;

  AST_PTR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !flush_i && ptr_q == LAST) |=> (ptr_q == '0)); // R9
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !flush_i && ptr_q != LAST) |=> (ptr_q == $past(ptr_q) + 1'b1)); // R9
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !flush_i) |=> $stable(ptr_q)); // R9
  AST_PTR_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (ptr_q == '0)); // R7
endmodule

// File: rtl/tlb_satcnt.sv
module tlb_satcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (inc_i && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_CNT_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '1) |=> (cnt_q == '1)); // R11
  AST_CNT_STEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && cnt_q != '1) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R11
  AST_CNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa #(
  parameter int N_ENTRIES = 8,
  parameter int VPN_W     = 20,
  parameter int ASID_W    = 8,
  parameter int PFN_W     = 20,
  parameter int CNT_W     = 16,
  localparam int IDX_W    = $clog2(N_ENTRIES),
  localparam int EW       = tlb_pkg::entry_width(VPN_W, ASID_W, PFN_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic              lk_hit_o,
  output logic [IDX_W-1:0]  lk_idx_o,
  output logic [EW-1:0]     lk_entry_o,
  input  logic [VPN_W-1:0]  pb_vpn_i,
  input  logic [ASID_W-1:0] pb_asid_i,
  output logic [IDX_W:0]    pb_idx_o,
  input  logic              wr_en_i,
  input  logic [IDX_W:0]    wr_idx_i,
  input  logic [EW-1:0]     wr_entry_i,
  output logic              wr_err_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [EW-1:0]     rd_entry_o,
  input  logic              flush_i,
  input  logic              nu_adv_i,
  output logic [IDX_W-1:0]  nu_idx_o,
  output logic [EW-1:0]     nu_entry_o,
  output logic [CNT_W-1:0]  hit_cnt_o,
  output logic [CNT_W-1:0]  miss_cnt_o
);
  localparam int O_V0   = tlb_pkg::off_v0(PFN_W);
  localparam int O_V1   = tlb_pkg::off_v1(PFN_W);
  localparam int O_GLB  = tlb_pkg::off_glb(PFN_W);
  localparam int O_ASID = tlb_pkg::off_asid(PFN_W);
  localparam int O_MASK = tlb_pkg::off_mask(ASID_W, PFN_W);
  localparam int O_VPN  = tlb_pkg::off_vpn(VPN_W, ASID_W, PFN_W);

  logic [N_ENTRIES-1:0][EW-1:0] tab;
  logic                         pb_hit;
  logic [IDX_W-1:0]             pb_idx;
  logic [EW-1:0]                pb_entry;
  logic [IDX_W-1:0]             nu_ptr;

  tlb_store #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W), .EW(EW)) i_store (
    .clk_i, .rst_ni, .flush_i, .wr_en_i, .wr_idx_i, .wr_entry_i, .wr_err_o,
    .rd_idx_i, .rd_entry_o, .tab_o(tab)
  );

  tlb_match #(.N_ENTRIES(N_ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W),
              .IDX_W(IDX_W), .EW(EW)) i_lk_match (
    .tab_i(tab), .vpn_i(lk_vpn_i), .asid_i(lk_asid_i),
    .hit_o(lk_hit_o), .idx_o(lk_idx_o), .entry_o(lk_entry_o)
  );

  tlb_match #(.N_ENTRIES(N_ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W),
              .IDX_W(IDX_W), .EW(EW)) i_pb_match (
    .tab_i(tab), .vpn_i(pb_vpn_i), .asid_i(pb_asid_i),
    .hit_o(pb_hit), .idx_o(pb_idx), .entry_o(pb_entry)
  );

  assign pb_idx_o = pb_hit ? {1'b0, pb_idx} : '1;

  tlb_nlu #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) i_nlu (
    .clk_i, .rst_ni, .flush_i, .adv_i(nu_adv_i), .ptr_o(nu_ptr)
  );

  assign nu_idx_o   = nu_ptr;
  assign nu_entry_o = tab[nu_ptr];

  tlb_satcnt #(.CNT_W(CNT_W)) i_hit_cnt (
    .clk_i, .rst_ni, .inc_i(lk_valid_i && lk_hit_o), .cnt_o(hit_cnt_o)
  );

  tlb_satcnt #(.CNT_W(CNT_W)) i_miss_cnt (
    .clk_i, .rst_ni, .inc_i(lk_valid_i && !lk_hit_o), .cnt_o(miss_cnt_o)
  );

  AST_HIT_VPN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> (((lk_vpn_i ^ lk_entry_o[O_VPN +: VPN_W]) & ~lk_entry_o[O_MASK +: VPN_W]) == '0)); // R1
  AST_HIT_ASID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> (lk_entry_o[O_GLB] || lk_entry_o[O_ASID +: ASID_W] == lk_asid_i)); // R2
  AST_HIT_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> (lk_entry_o[O_V0] || lk_entry_o[O_V1])); // R4
  AST_PROBE_AGREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pb_vpn_i == lk_vpn_i && pb_asid_i == lk_asid_i)
      |-> (pb_idx_o == (lk_hit_o ? {1'b0, lk_idx_o} : {(IDX_W+1){1'b1}}))); // R3
  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> (lk_idx_o == '0 && lk_entry_o == '0)); // R10
endmodule

// File: tb/test_tlb_fa.sv
module test_tlb_fa;
  localparam int N  = 8;
  localparam int VW = 20;
  localparam int AW = 8;
  localparam int PW = 20;
  localparam int CW = 4;
  localparam int IW = 3;
  localparam int EW = 2*VW + AW + 3 + 2*PW;
  localparam int CMAX = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          lk_valid = 0;
  logic [VW-1:0] lk_vpn = '0;
  logic [AW-1:0] lk_asid = '0;
  logic          lk_hit;
  logic [IW-1:0] lk_idx;
  logic [EW-1:0] lk_entry;
  logic [VW-1:0] pb_vpn = '0;
  logic [AW-1:0] pb_asid = '0;
  logic [IW:0]   pb_idx;
  logic          wr_en = 0;
  logic [IW:0]   wr_idx = '0;
  logic [EW-1:0] wr_entry = '0;
  logic          wr_err;
  logic [IW-1:0] rd_idx = '0;
  logic [EW-1:0] rd_entry;
  logic          flush = 0;
  logic          nu_adv = 0;
  logic [IW-1:0] nu_idx;
  logic [EW-1:0] nu_entry;
  logic [CW-1:0] hit_cnt, miss_cnt;

  tlb_fa #(.N_ENTRIES(N), .VPN_W(VW), .ASID_W(AW), .PFN_W(PW), .CNT_W(CW)) i_tlb_fa (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_vpn_i(lk_vpn), .lk_asid_i(lk_asid),
    .lk_hit_o(lk_hit), .lk_idx_o(lk_idx), .lk_entry_o(lk_entry),
    .pb_vpn_i(pb_vpn), .pb_asid_i(pb_asid), .pb_idx_o(pb_idx),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_entry_i(wr_entry), .wr_err_o(wr_err),
    .rd_idx_i(rd_idx), .rd_entry_o(rd_entry), .flush_i(flush),
    .nu_adv_i(nu_adv), .nu_idx_o(nu_idx), .nu_entry_o(nu_entry),
    .hit_cnt_o(hit_cnt), .miss_cnt_o(miss_cnt)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [EW-1:0] m_tab [N];
  int m_ptr = 0;
  int m_hit = 0;
  int m_miss = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [EW-1:0] mk(input logic [VW-1:0] vpn, input logic [VW-1:0] msk,
      input logic [AW-1:0] asid, input bit g, input bit v1, input bit v0,
      input logic [PW-1:0] p1, input logic [PW-1:0] p0);
    return {vpn, msk, asid, g, v1, v0, p1, p0};
  endfunction

  // reference search: lowest live slot matching outside its mask
  function automatic int m_find(input logic [VW-1:0] vpn, input logic [AW-1:0] asid);
    for (int i = 0; i < N; i++) begin
      logic [EW-1:0] e = m_tab[i];
      logic [VW-1:0] ev = e[EW-1 -: VW];
      logic [VW-1:0] em = e[EW-VW-1 -: VW];
      logic [AW-1:0] ea = e[2*PW+3 +: AW];
      bit live = e[2*PW] | e[2*PW+1];
      if (live && (((vpn ^ ev) & ~em) == '0) && (e[2*PW+2] || ea == asid)) return i;
    end
    return -1;
  endfunction

  task automatic do_write(input int idx, input logic [EW-1:0] e);
    wr_en = 1; wr_idx = (IW+1)'(idx); wr_entry = e;
    @(posedge clk);
    if (idx < N) m_tab[idx] = e;
    #1 wr_en = 0;
    @(negedge clk);
    chk(wr_err == (idx >= N), "R6 wr_err after write", wr_err, idx >= N);
    @(posedge clk); #1;
  endtask

  task automatic do_lookup(input logic [VW-1:0] vpn, input logic [AW-1:0] asid, input bit strb, input string req);
    int x;
    lk_vpn = vpn; lk_asid = asid; pb_vpn = vpn; pb_asid = asid; lk_valid = strb;
    @(negedge clk);
    x = m_find(vpn, asid);
    chk(lk_hit == (x >= 0), {req, " hit"}, lk_hit, x >= 0);
    chk(lk_idx == ((x >= 0) ? IW'(x) : '0), {req, " R10 idx"}, lk_idx, x);
    chk(lk_entry == ((x >= 0) ? m_tab[x] : '0), {req, " R10 entry"}, lk_entry, (x >= 0) ? m_tab[x] : '0);
    chk(pb_idx == ((x >= 0) ? (IW+1)'(x) : '1), {req, " R3 probe"}, pb_idx, x);
    @(posedge clk);
    if (strb) begin
      if (x >= 0) m_hit = (m_hit < CMAX) ? m_hit + 1 : CMAX;
      else        m_miss = (m_miss < CMAX) ? m_miss + 1 : CMAX;
    end
    #1 lk_valid = 0;
  endtask

  task automatic rd_check(input int i);
    rd_idx = IW'(i);
    @(negedge clk);
    chk(rd_entry == m_tab[i], "R8 indexed read", rd_entry, m_tab[i]);
    @(posedge clk); #1;
  endtask

  task automatic nu_step(input bit adv);
    nu_adv = adv;
    @(negedge clk);
    chk(nu_idx == IW'(m_ptr), "R9 pointer", nu_idx, m_ptr);
    chk(nu_entry == m_tab[m_ptr], "R9 next-use entry", nu_entry, m_tab[m_ptr]);
    @(posedge clk);
    if (adv) m_ptr = (m_ptr + 1) % N;
    #1 nu_adv = 0;
  endtask

  task automatic cnt_check();
    @(negedge clk);
    chk(hit_cnt == CW'(m_hit), "R11 hit count", hit_cnt, m_hit);
    chk(miss_cnt == CW'(m_miss), "R11 miss count", miss_cnt, m_miss);
    @(posedge clk); #1;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [VW-1:0] bases [4];
    logic [VW-1:0] masks [4];
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < N; i++) m_tab[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // reset state
    @(negedge clk);
    chk(lk_hit == 0, "R10 reset miss", lk_hit, 0);
    chk(pb_idx == '1, "R3 reset probe -1", pb_idx, '1);
    chk(wr_err == 0, "R6 reset err", wr_err, 0);
    chk(nu_idx == 0, "R9 reset pointer", nu_idx, 0);
    chk(hit_cnt == 0 && miss_cnt == 0, "R11 reset counts", {hit_cnt, miss_cnt}, 0);
    @(posedge clk); #1;

    // mask compare
    do_write(0, mk(20'h12340, 20'h0000F, 8'd5, 0, 0, 1, 20'h1, 20'h2));
    do_lookup(20'h1234A, 8'd5, 1, "R1 masked bits ignored");
    do_lookup(20'h12350, 8'd5, 1, "R1 unmasked bit differs");
    do_lookup(20'h1234A, 8'd6, 1, "R2 asid mismatch");
    // global slot
    do_write(1, mk(20'h55500, 20'h0, 8'd9, 1, 1, 1, 20'h3, 20'h4));
    do_lookup(20'h55500, 8'd3, 1, "R2 global any asid");
    // dead and v1-only slots
    do_write(2, mk(20'h77700, 20'h0, 8'd1, 1, 0, 0, 20'h5, 20'h6));
    do_lookup(20'h77700, 8'd1, 1, "R4 dead slot misses");
    do_write(3, mk(20'h77700, 20'h0, 8'd1, 0, 1, 0, 20'h7, 20'h8));
    do_lookup(20'h77700, 8'd1, 1, "R4 v1-only slot live");
    // overlapping slots, lowest wins
    do_write(6, mk(20'h88800, 20'h000FF, 8'd0, 1, 0, 1, 20'h9, 20'hA));
    do_write(4, mk(20'h88800, 20'h0000F, 8'd0, 1, 0, 1, 20'hB, 20'hC));
    do_lookup(20'h88805, 8'd7, 1, "R10 lowest index wins");
    do_lookup(20'h88855, 8'd7, 1, "R10 only wider slot");

    // write not visible in its own cycle, visible after
    wr_en = 1; wr_idx = 4'd5; wr_entry = mk(20'h99900, 20'h0, 8'd2, 1, 0, 1, 20'hD, 20'hE);
    lk_vpn = 20'h99900; lk_asid = 8'd2;
    @(negedge clk);
    chk(lk_hit == 0, "R5 not visible during write", lk_hit, 0);
    @(posedge clk);
    m_tab[5] = wr_entry;
    #1 wr_en = 0;
    @(negedge clk);
    chk(lk_hit == 1 && lk_idx == 3'd5, "R5 visible next cycle", {lk_hit, lk_idx}, {1'b1, 3'd5});
    @(posedge clk); #1;

    // out-of-range writes
    do_write(8, mk(20'hFFFFF, 20'h0, 8'd0, 1, 1, 1, 20'h1, 20'h1));
    @(negedge clk);
    chk(wr_err == 0, "R6 err lasts one cycle", wr_err, 0);
    @(posedge clk); #1;
    do_write(15, '1);
    do_lookup(20'hFFFFF, 8'd0, 1, "R6 dropped write no hit");
    for (int i = 0; i < N; i++) rd_check(i);

    // next-use pointer with wrap and hold
    nu_step(0);
    for (int i = 0; i < N + 3; i++) nu_step(1);
    nu_step(0);
    nu_step(0);

    // counter saturation
    for (int i = 0; i < 18; i++) do_lookup(20'h55500, 8'd0, 1, "R11 saturation");
    do_lookup(20'h55500, 8'd0, 0, "R11 no strobe");
    cnt_check();

    // flush with pending write and advance
    flush = 1; nu_adv = 1; wr_en = 1; wr_idx = 4'd0; wr_entry = '1;
    @(posedge clk);
    for (int i = 0; i < N; i++) m_tab[i] = '0;
    m_ptr = 0;
    #1 flush = 0; nu_adv = 0; wr_en = 0;
    for (int i = 0; i < N; i++) rd_check(i);
    nu_step(0);
    do_lookup(20'h55500, 8'd9, 0, "R7 flushed misses");
    cnt_check();

    // seeded random mix
    bases[0] = 20'h0A000; bases[1] = 20'h0A100; bases[2] = 20'h3C000; bases[3] = 20'h3C0F0;
    masks[0] = 20'h0; masks[1] = 20'h0000F; masks[2] = 20'h000FF; masks[3] = 20'h00003;
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 9);
      logic [VW-1:0] v = bases[$urandom_range(0, 3)] | VW'($urandom_range(0, 31));
      logic [AW-1:0] a = AW'($urandom_range(0, 3));
      if (op < 3) begin
        do_write($urandom_range(0, 9),
                 mk(v, masks[$urandom_range(0, 3)], a, ($urandom_range(0, 3) == 0),
                    1'($urandom), 1'($urandom), PW'($urandom), PW'($urandom)));
      end else if (op < 7) begin
        do_lookup(v, a, 1'($urandom), "R1 R2 R4 random lookup");
      end else if (op == 7) begin
        rd_check($urandom_range(0, N-1));
      end else if (op == 8) begin
        nu_step(1'($urandom));
      end else begin
        cnt_check();
      end
    end
    cnt_check();
    report();
  end
endmodule